// File: doc/BRIEF.md
# Interrupt Routing Table Locator

This block hunts through a read-only memory region for the header of an interrupt routing table and reports the byte address where the table begins. It owns a plain synchronous read port: it drives an address with a read enable, and the byte comes back on the following cycle. A scan begins on a start pulse. If the caller supplies a nonzero preferred address, that location is tried first. The block sweeps the configured window on 16-byte boundaries only when the preferred attempt fails or when no preferred address is given.

Every candidate is judged as its bytes stream in, one read per cycle. The first eight bytes must carry the four-byte tag, the version word and a usable length. Once the header passes, the block reads the rest of the table and keeps an 8-bit running sum. The candidate is accepted only if that sum wraps to zero at the last byte. When a candidate fails, its in-flight read is discarded and the next candidate starts on the following cycle. The scan ends with a one-cycle done pulse. A found flag and the table address go with the pulse and stay valid until the next scan starts.

Top module: `irq_table_locator`

## Requirements
- R1: After reset, done, found and rd_en are low and tbl_addr is zero.
- R2: A start pulse while idle begins a scan. A start pulse during a scan is ignored: the scan's result and its completion cycle are unchanged.
- R3: When pref_addr is nonzero at start, that address is the first candidate, and the window is swept only if it fails. When pref_addr is zero, the sweep begins at the window base.
- R4: The sweep visits WIN_BASE, WIN_BASE+16, and so on, stopping before WIN_END (default 0xF0000 up to, not including, 0x100000). Addresses outside the window are never accepted by the sweep, and the lowest passing candidate wins.
- R5: Bytes at offsets 0..3 of a candidate must be 0x24, 0x50, 0x49, 0x52 (the ASCII tag "$PIR" read as a little-endian word).
- R6: The little-endian version word at offsets 4..5 must be 0x0100, so byte 4 is 0x00 and byte 5 is 0x01.
- R7: The little-endian length word at offsets 6..7 must be a multiple of 16 and at least 32.
- R8: The 8-bit wrapping sum of the bytes from offset 0 through offset length-1 must be zero.
- R9: done is high for exactly one cycle per scan. With it, found is high and tbl_addr holds the accepted base, or, if no candidate passed, found is low and tbl_addr is zero.
- R10: found and tbl_addr hold their values after done until the next accepted start. They read zero for the whole of the following scan.
- R11: Reads are issued one per cycle from offset 0 of each candidate. A candidate rejected on header byte k costs k+2 cycles. A candidate judged on its checksum costs length+1 cycles. done rises on the cycle after the last judgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Scan request pulse |
| pref_addr | input | AW | Preferred first candidate, zero for none |
| rd_en | output | 1 | Read request to memory |
| rd_addr | output | AW | Byte address of the read |
| rd_data | input | 8 | Read byte, valid the cycle after rd_en |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | A table was accepted |
| tbl_addr | output | AW | Base of the accepted table |

## Verification
The assertions assume that memory returns a byte exactly one cycle after each read request. They also assume pref_addr stays steady from the start pulse until done, because the placement check compares the reported base against the live pref_addr. The bench changes pref_addr only between scans. Its memory model answers every read on the next edge, and it returns zero for bytes that were never written. The stimulus places valid tables, near misses and out-of-window tables at chosen addresses, and drives start only at quiet points or as a deliberate mid-scan poke.

// File: rtl/irq_table_locator.sv
module irq_table_locator #(
  parameter int AW = 32,
  parameter logic [AW-1:0] WIN_BASE = 32'h000F_0000,
  parameter logic [AW-1:0] WIN_END  = 32'h0010_0000,
  parameter int STEP = 16,
  parameter int HDR_LEN = 32,
  parameter logic [31:0] SIG = 32'h5249_5024,
  parameter logic [15:0] VERSION = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] pref_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          done,
  output logic          found,
  output logic [AW-1:0] tbl_addr
);
  localparam int OW = 17;

  logic          busy, in_pref, vld;
  logic [AW-1:0] base;
  logic [OW-1:0] off, voff;
  logic [7:0]    size_lo, sum;
  logic [15:0]   size_q;
  logic [7:0]    exp_b;

  wire logic [7:0] sum_nx = sum + rd_data;

  always_comb begin
    case (voff[2:0])
      3'd0:    exp_b = SIG[7:0];
      3'd1:    exp_b = SIG[15:8];
      3'd2:    exp_b = SIG[23:16];
      3'd3:    exp_b = SIG[31:24];
      3'd4:    exp_b = VERSION[7:0];
      3'd5:    exp_b = VERSION[15:8];
      default: exp_b = 8'h00;
    endcase
  end

  wire logic in_hdr  = vld && (voff < OW'(8));
  wire logic hdr_bad = in_hdr && (
                         ((voff < OW'(6)) && (rd_data != exp_b)) ||
                         ((voff == OW'(6)) && (rd_data[3:0] != 4'h0)) ||
                         ((voff == OW'(7)) && ({rd_data, size_lo} < 16'(HDR_LEN))));
  wire logic last    = vld && !in_hdr && ((voff + OW'(1)) == {1'b0, size_q});
  wire logic accept  = last && (sum_nx == 8'h00);
  wire logic reject  = hdr_bad || (last && (sum_nx != 8'h00));
  wire logic win_last = ({1'b0, base} + (AW+1)'(STEP)) >= {1'b0, WIN_END};

  assign rd_en   = busy && ((off < OW'(9)) || (off < {1'b0, size_q}));
  assign rd_addr = base + AW'(off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; in_pref <= 1'b0; vld <= 1'b0;
      base <= '0; off <= '0; voff <= '0;
      size_lo <= '0; size_q <= '0; sum <= '0;
      done <= 1'b0; found <= 1'b0; tbl_addr <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          found    <= 1'b0;
          tbl_addr <= '0;
          in_pref  <= (pref_addr != '0);
          base     <= (pref_addr != '0) ? pref_addr : WIN_BASE;
          off      <= '0;
          vld      <= 1'b0;
          sum      <= '0;
          size_q   <= '0;
        end
      end else begin
        vld  <= rd_en;
        voff <= off;
        if (rd_en) off <= off + OW'(1);
        if (vld) begin
          sum <= sum_nx;
          if (voff == OW'(6)) size_lo <= rd_data;
          if (voff == OW'(7)) size_q  <= {rd_data, size_lo};
        end
        if (accept) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          found    <= 1'b1;
          tbl_addr <= base;
          vld      <= 1'b0;
        end else if (reject) begin
          vld    <= 1'b0;
          off    <= '0;
          sum    <= '0;
          size_q <= '0;
          if (in_pref) begin
            in_pref <= 1'b0;
            base    <= WIN_BASE;
          end else if (win_last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            base <= base + AW'(STEP);
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_table_locator_chk.sv
module irq_table_locator_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] WIN_BASE = 32'h000F_0000,
  parameter logic [AW-1:0] WIN_END  = 32'h0010_0000,
  parameter int STEP = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] pref_addr,
  input logic          rd_en,
  input logic          done,
  input logic          found,
  input logic [AW-1:0] tbl_addr,
  input logic          busy
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (tbl_addr == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (done || ($stable(found) && $stable(tbl_addr))));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !found && (tbl_addr == '0)));

  p_read_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  p_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> ((tbl_addr == pref_addr) ||
      ((tbl_addr >= WIN_BASE) && (tbl_addr < WIN_END) &&
       (((tbl_addr - WIN_BASE) % AW'(STEP)) == '0))));
endmodule

bind irq_table_locator irq_table_locator_chk #(
  .AW(AW), .WIN_BASE(WIN_BASE), .WIN_END(WIN_END), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pref_addr(pref_addr),
  .rd_en(rd_en), .done(done), .found(found), .tbl_addr(tbl_addr),
  .busy(busy)
);

// File: tb/tb_irq_table_locator.sv
`timescale 1ns/1ps
module tb_irq_table_locator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pref_addr = '0;
  logic        rd_en;
  logic [31:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        done, found;
  logic [31:0] tbl_addr;

  int errors = 0;
  int checks = 0;
  bit [7:0] mem [int unsigned];

  always #2 clk = ~clk;

  irq_table_locator dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_addr(pref_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .found(found), .tbl_addr(tbl_addr)
  );

  function automatic bit [7:0] m(input int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= m(rd_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_table(input int unsigned a, input int size,
                           input bit [15:0] ver, input bit [31:0] sig,
                           input bit [7:0] skew);
    bit [7:0] s;
    mem[a+0] = sig[7:0];   mem[a+1] = sig[15:8];
    mem[a+2] = sig[23:16]; mem[a+3] = sig[31:24];
    mem[a+4] = ver[7:0];   mem[a+5] = ver[15:8];
    mem[a+6] = size[7:0];  mem[a+7] = size[15:8];
    for (int k = 8; k < size; k++) mem[a+k] = 8'((a + k*7) & 8'hff);
    if (size > 8) begin
      s = 0;
      mem[a+8] = 0;
      for (int k = 0; k < size; k++) s += m(a+k);
      mem[a+8] = 8'(-s) + skew;
    end
  endtask

  // Behavioural judgement of one candidate: cost in cycles and verdict.
  function automatic void judge(input int unsigned a, output int cost, output bit ok);
    bit [7:0] want [6] = '{8'h24, 8'h50, 8'h49, 8'h52, 8'h00, 8'h01};
    int size;
    bit [7:0] s;
    for (int k = 0; k < 6; k++)
      if (m(a+k) != want[k]) begin cost = k + 2; ok = 0; return; end
    if (m(a+6) % 16 != 0) begin cost = 8; ok = 0; return; end
    size = {m(a+7), m(a+6)};
    if (size < 32) begin cost = 9; ok = 0; return; end
    s = 0;
    for (int k = 0; k < size; k++) s += m(a+k);
    cost = size + 1;
    ok = (s == 0);
  endfunction

  function automatic void predict(input int unsigned pref, output bit f,
                                  output int unsigned addr, output int t);
    int c; bit ok;
    t = 0; f = 0; addr = 0;
    if (pref != 0) begin
      judge(pref, c, ok); t += c;
      if (ok) begin f = 1; addr = pref; return; end
    end
    for (int unsigned a = 32'hF0000; a < 32'h100000; a += 16) begin
      judge(a, c, ok); t += c;
      if (ok) begin f = 1; addr = a; return; end
    end
  endfunction

  task automatic run_scan(input int unsigned pref, input string req, input int poke);
    bit ef; int unsigned ea; int t;
    predict(pref, ef, ea, t);
    pref_addr = pref;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 1; i <= t; i++) begin
      start = (i == poke);
      @(negedge clk);
      chk(done == (i == t), req, "done timing", 32'(done), 32'(i == t));
      if (i < t) chk(found == 1'b0, "R10", "found during scan", 32'(found), 0);
    end
    start = 1'b0;
    chk(found == ef, req, "found", 32'(found), 32'(ef));
    chk(tbl_addr == ea, req, "tbl_addr", tbl_addr, ea);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single pulse", 32'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(done == 0 && found == 0 && rd_en == 0, "R1", "idle outputs", {done, found, rd_en}, 0);
    chk(tbl_addr == 0, "R1", "tbl_addr reset", tbl_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R9: empty window, no table
    run_scan(0, "R9", 0);

    // R5 R6 R7 R8: one valid table
    put_table(32'hF5A30, 48, 16'h0100, 32'h52495024, 0);
    run_scan(0, "R8", 0);
    // R10: result held while idle
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(found && tbl_addr == 32'hF5A30, "R10", "held result", tbl_addr, 32'hF5A30);
    end
    // R2: start poke mid-scan is ignored
    run_scan(0, "R2", 500);

    // R8: bad checksum skipped
    mem.delete();
    put_table(32'hF1000, 64, 16'h0100, 32'h52495024, 8'h01);
    put_table(32'hF2000, 32, 16'h0100, 32'h52495024, 0);
    run_scan(0, "R8", 0);

    // R5 R6 R7: header near misses before a minimum-size good table
    mem.delete();
    put_table(32'hF0100, 32, 16'h0101, 32'h52495024, 0);
    put_table(32'hF0200, 40, 16'h0100, 32'h52495024, 0);
    put_table(32'hF0300, 16, 16'h0100, 32'h52495024, 0);
    put_table(32'hF0400, 32, 16'h0100, 32'h49525024, 0);
    put_table(32'hF0480, 32, 16'h0001, 32'h52495024, 0);
    put_table(32'hF0500, 32, 16'h0100, 32'h52495024, 0);
    run_scan(0, "R5", 0);
    chk(tbl_addr == 32'hF0500, "R6", "version and size rejects", tbl_addr, 32'hF0500);
    chk(tbl_addr == 32'hF0500, "R7", "length rule", tbl_addr, 32'hF0500);

    // R4: first of two wins
    mem.delete();
    put_table(32'hF9000, 32, 16'h0100, 32'h52495024, 0);
    put_table(32'hF8000, 32, 16'h0100, 32'h52495024, 0);
    run_scan(0, "R4", 0);

    // R4: tables just outside the window are not found
    mem.delete();
    put_table(32'hEFFF0, 32, 16'h0100, 32'h52495024, 0);
    put_table(32'h100000, 32, 16'h0100, 32'h52495024, 0);
    run_scan(0, "R4", 0);

    // R4: last candidate, table running past the window end
    put_table(32'hFFFF0, 32, 16'h0100, 32'h52495024, 0);
    run_scan(0, "R4", 0);

    // R3: valid preferred address wins over window
    mem.delete();
    put_table(32'h00000508, 64, 16'h0100, 32'h52495024, 0);
    put_table(32'hF0000, 32, 16'h0100, 32'h52495024, 0);
    run_scan(32'h00000508, "R3", 0);

    // R3: invalid preferred address falls back to window
    mem.delete();
    put_table(32'hF7770, 32, 16'h0100, 32'h52495024, 0);
    run_scan(32'h00000600, "R3", 0);

    // R11: read stream from offset 0 of a preferred candidate
    pref_addr = 32'h00000508;
    put_table(32'h00000508, 32, 16'h0100, 32'h52495024, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 32; k++) begin
      chk(rd_en && rd_addr == 32'h508 + k, "R11", "read address", rd_addr, 32'h508 + k);
      @(negedge clk);
    end
    @(negedge clk);
    chk(done && found && tbl_addr == 32'h508, "R11", "done after stream", tbl_addr, 32'h508);
    pref_addr = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule